// File: doc/BRIEF.md
# Privilege Ring Instruction Gate

This block keeps the current privilege level of an execution core and decides whether each incoming instruction may run at that level. Every instruction class needs a minimum level. When the current level is numerically at or below that level, the gate gives an execute grant. Otherwise it raises a fault request. Level 0 is the most privileged of the four levels and level 3 the least.

The level is not stored in a register of its own. It is held in the two low bits of two selector registers, a code selector and a stack selector, and these two copies always agree. Only two kinds of event can move the level: a trap entry, which covers both interrupts and system calls, and a trap return. An ordinary software write to a selector can change its upper bits but never its level bits. A write that tries to change the level bits raises a fault.

Top module: `priv_ring_gate`

## Requirements
- R1: After synchronous reset the level is 0, both selectors read 0, and grant and fault are low.
- R2: The 3-bit instruction class c needs level 3 - floor(c/2). A valid instruction whose class is permitted gives grant high on the cycle after the strobe.
- R3: A valid instruction whose class needs a numerically lower level than the current level gives fault high and grant low on the cycle after the strobe. Grant and fault are never high together.
- R4: At level 0 every class is granted. At level 3 only classes 0 and 1 are granted.
- R5: A trap entry strobe sets the level to 0 in both selectors on the next cycle.
- R6: A trap return strobe loads the supplied return level into both selectors on the next cycle. When entry and return are strobed together, entry wins.
- R7: With no trap strobe the level does not change, and bits 1:0 of the two selectors are always equal.
- R8: A selector write (target 1 = code, 0 = stack) loads data bits 15:2 into that selector and leaves bits 1:0 unchanged. If data bits 1:0 differ from the current level, fault is high on the next cycle.
- R9: A cycle with no valid instruction and no mismatched selector write gives grant and fault low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_class | input | 3 | Instruction class code |
| trap_enter | input | 1 | Interrupt or system-call entry strobe |
| trap_return | input | 1 | Trap return strobe |
| return_level | input | 2 | Level restored by a trap return |
| sel_wr_en | input | 1 | Ordinary selector write strobe |
| sel_wr_target | input | 1 | 1 writes the code selector, 0 the stack selector |
| sel_wr_data | input | 16 | Selector write data |
| grant | output | 1 | Execute grant for the previous cycle's instruction |
| fault | output | 1 | Fault request for the previous cycle |
| cur_level | output | 2 | Current privilege level |
| code_sel | output | 16 | Code selector value |
| stack_sel | output | 16 | Stack selector value |

## Verification
The assertions treat the strobes as synchronous single-cycle inputs with known values outside reset. They allow any mix of instruction, trap and write in the same cycle. The bench drives every input on the falling edge, holds it for one full cycle and then clears it. Levels are reached only through trap return and trap entry, as the design allows. The class sweep at each level therefore starts from a level the gate itself reports.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;
    localparam int LEVELS = 4;
    typedef logic [1:0] level_t;

    // Minimum required level for class c out of n classes:
    // classes are split into four equal groups, lowest group least privileged.
    function automatic level_t req_level(input int c, input int n);
        int grp;
        grp = (c * LEVELS) / n;
        return level_t'(LEVELS - 1 - grp);
    endfunction
endpackage

// File: rtl/pg_selector_pair.sv
module pg_selector_pair
    import priv_gate_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    input  logic             ret,
    input  level_t           ret_level,
    input  logic             wr_en,
    input  logic             wr_target,
    input  logic [SEL_W-1:0] wr_data,
    output logic [SEL_W-1:0] code_sel,
    output logic [SEL_W-1:0] stack_sel,
    output level_t           level,
    output logic             wr_mismatch
);
    localparam int HI_W = SEL_W - 2;

    logic [HI_W-1:0] code_hi, stack_hi;
    level_t          code_lvl, stack_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_hi   <= '0;
            stack_hi  <= '0;
            code_lvl  <= '0;
            stack_lvl <= '0;
        end else begin
            if (wr_en && wr_target)  code_hi  <= wr_data[SEL_W-1:2];
            if (wr_en && !wr_target) stack_hi <= wr_data[SEL_W-1:2];
            if (enter) begin
                code_lvl  <= '0;
                stack_lvl <= '0;
            end else if (ret) begin
                code_lvl  <= ret_level;
                stack_lvl <= ret_level;
            end
        end
    end

    assign code_sel    = {code_hi, code_lvl};
    assign stack_sel   = {stack_hi, stack_lvl};
    assign level       = code_lvl;
    assign wr_mismatch = wr_en && (wr_data[1:0] != code_lvl);

    p_copies_equal_r7: assert property (@(posedge clk) disable iff (rst)
        code_sel[1:0] == stack_sel[1:0]);
    p_level_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!enter && !ret) |=> $stable(level));
    p_enter_zero_r5: assert property (@(posedge clk) disable iff (rst)
        enter |=> (code_sel[1:0] == 2'd0));
    p_return_load_r6: assert property (@(posedge clk) disable iff (rst)
        (ret && !enter) |=> (stack_sel[1:0] == $past(ret_level)));
endmodule

// File: rtl/pg_class_check.sv
module pg_class_check
    import priv_gate_pkg::*;
#(
    parameter int CLASS_W = 3
) (
    input  level_t             level,
    input  logic [CLASS_W-1:0] cls,
    output logic               allowed
);
    localparam int NUM_CLASSES = 1 << CLASS_W;

    logic [NUM_CLASSES-1:0] allow_vec;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        localparam level_t REQ = req_level(c, NUM_CLASSES);
        assign allow_vec[c] = (level <= REQ);
    end

    assign allowed = allow_vec[cls];

    always_comb begin
        if (level == 2'd0) p_lvl0_all_r4: assert (allowed);
    end
endmodule

// File: rtl/priv_ring_gate.sv
module priv_ring_gate
    import priv_gate_pkg::*;
#(
    parameter int CLASS_W = 3,
    parameter int SEL_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [CLASS_W-1:0] instr_class,
    input  logic               trap_enter,
    input  logic               trap_return,
    input  logic [1:0]         return_level,
    input  logic               sel_wr_en,
    input  logic               sel_wr_target,
    input  logic [SEL_W-1:0]   sel_wr_data,
    output logic               grant,
    output logic               fault,
    output logic [1:0]         cur_level,
    output logic [SEL_W-1:0]   code_sel,
    output logic [SEL_W-1:0]   stack_sel
);
    level_t level;
    logic   allowed, wr_mismatch;
    logic   grant_q, fault_q;

    pg_selector_pair #(.SEL_W(SEL_W)) sel_i (
        .clk(clk), .rst(rst),
        .enter(trap_enter), .ret(trap_return), .ret_level(return_level),
        .wr_en(sel_wr_en), .wr_target(sel_wr_target), .wr_data(sel_wr_data),
        .code_sel(code_sel), .stack_sel(stack_sel),
        .level(level), .wr_mismatch(wr_mismatch)
    );

    pg_class_check #(.CLASS_W(CLASS_W)) chk_i (
        .level(level), .cls(instr_class), .allowed(allowed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            grant_q <= instr_valid && allowed && !wr_mismatch;
            fault_q <= (instr_valid && !allowed) || wr_mismatch;
        end
    end

    assign grant     = grant_q;
    assign fault     = fault_q;
    assign cur_level = level;

    p_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(grant && fault));
    p_deny_fault_r3: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !allowed) |=> (fault && !grant));
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!instr_valid && !wr_mismatch) |=> (!grant && !fault));
    p_lvl3_only_low_r4: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && level == 2'd3 && instr_class >= CLASS_W'(2) && !sel_wr_en)
        |=> fault);
endmodule

// File: tb/priv_ring_gate_tb_top.sv
module priv_ring_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid, trap_enter, trap_return, sel_wr_en, sel_wr_target;
    logic [2:0]  instr_class;
    logic [1:0]  return_level, cur_level;
    logic [15:0] sel_wr_data, code_sel, stack_sel;
    logic        grant, fault;
    int          errors = 0, checks = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    priv_ring_gate dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_class(instr_class),
        .trap_enter(trap_enter), .trap_return(trap_return), .return_level(return_level),
        .sel_wr_en(sel_wr_en), .sel_wr_target(sel_wr_target), .sel_wr_data(sel_wr_data),
        .grant(grant), .fault(fault), .cur_level(cur_level),
        .code_sel(code_sel), .stack_sel(stack_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        instr_valid = 0; trap_enter = 0; trap_return = 0; sel_wr_en = 0;
        instr_class = 0; return_level = 0; sel_wr_target = 0; sel_wr_data = 0;
    endtask

    task automatic cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic go_level(input int l);
        trap_return = 1; return_level = 2'(l);
        cycle();
    endtask

    task automatic check_level(input int l, input string tag);
        check(cur_level == 2'(l) && code_sel[1:0] == 2'(l) && stack_sel[1:0] == 2'(l),
              tag, {code_sel[1:0], stack_sel[1:0]}, {2'(l), 2'(l)});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check(cur_level == 0 && code_sel == 0 && stack_sel == 0 && !grant && !fault,
              "R1 reset", {grant, fault, cur_level}, 0);

        // R2 R3 R4: full sweep of level x class
        for (int l = 0; l < 4; l++) begin
            go_level(l);
            check_level(l, "R6 return load");
            for (int c = 0; c < 8; c++) begin
                int req;
                bit ok;
                req = 3 - c / 2;
                ok = (l <= req);
                instr_valid = 1; instr_class = 3'(c);
                cycle();
                check(grant == ok && fault == !ok, ok ? "R2 grant" : "R3 fault",
                      {grant, fault}, {ok, !ok});
                if (l == 0 || l == 3)
                    check(grant == ok, "R4 level edge", grant, ok);
                check(!(grant && fault), "R3 exclusive", {grant, fault}, 0);
            end
            // R9 idle
            cycle();
            check(!grant && !fault, "R9 idle quiet", {grant, fault}, 0);
            check_level(l, "R7 hold");
        end

        // R5 trap entry from level 3
        go_level(3);
        trap_enter = 1;
        cycle();
        check_level(0, "R5 entry zero");
        // R6 entry wins over return
        go_level(2);
        trap_enter = 1; trap_return = 1; return_level = 2'd3;
        cycle();
        check_level(0, "R6 entry priority");

        // R8 selector writes at level 1
        go_level(1);
        sel_wr_en = 1; sel_wr_target = 1; sel_wr_data = 16'hABCD;
        cycle();
        check(code_sel == 16'hABCD && !fault, "R8 code write match", code_sel, 16'hABCD);
        sel_wr_en = 1; sel_wr_target = 1; sel_wr_data = 16'h1236;
        cycle();
        check(code_sel == 16'h1235, "R8 code low bits kept", code_sel, 16'h1235);
        check(fault && !grant, "R8 mismatch fault", {grant, fault}, 1);
        sel_wr_en = 1; sel_wr_target = 0; sel_wr_data = 16'h8880;
        cycle();
        check(stack_sel == 16'h8881 && code_sel == 16'h1235, "R8 stack low bits kept",
              stack_sel, 16'h8881);
        check(fault, "R8 stack mismatch fault", fault, 1);
        check_level(1, "R7 write no level change");
        // R8 mismatched write with a permitted instruction: fault wins
        sel_wr_en = 1; sel_wr_target = 0; sel_wr_data = 16'h0003;
        instr_valid = 1; instr_class = 3'd0;
        cycle();
        check(fault && !grant, "R8 write fault with instr", {grant, fault}, 1);
        check(stack_sel == 16'h0001, "R8 stack upper written", stack_sel, 16'h0001);

        // R1 reset again from nonzero
        go_level(3);
        rst = 1;
        cycle();
        rst = 0;
        check(cur_level == 0 && code_sel == 0 && stack_sel == 0, "R1 re-reset",
              code_sel, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule